// File: doc/BRIEF.md
# I2C Slave Engine with FIFO-Driven Acknowledge

This block is the slave side of an I2C interface with 7-bit addressing. It oversamples the SCL and SDA lines with the system clock. Each line passes through a two-flop synchronizer and a two-sample glitch filter. The block then detects START and STOP conditions and shifts bytes on the SCL edges. Bytes that a master writes land in a two-entry receive FIFO. Bytes that a master reads come from a two-entry transmit FIFO, which software fills.

The acknowledge the slave returns depends on the state of its queues:
- It refuses a read of its address when there is nothing queued to send.
- It refuses a written byte when the receive queue has no room, and when the software refusal input is set.
- When the transmit queue runs dry partway through a read, it sends the previous byte again.

Address 0x00 and address 0x01 are general-call addresses. The byte after either one is taken as a command byte. After address 0x00, two command values update the general-call status and a two-bit identifier. One of them also pulses an interface reset.

Status flags are sticky and each is cleared by its bit of a write-one-to-clear strobe. An interrupt line is the OR of the flags and the receive-ready indication. A separate block can hold SCL low through a hold request. That request takes effect only while the slave is taking part in a transfer.

Top module: `i2c_fifo_slave`

## Requirements
- R1: After reset the slave drives neither line (`sda_oe`=0, `scl_oe`=0), both queues are empty (`rx_req`=0, `tx_full`=0), and all flags, `gcid`, `if_reset` and `irq` are 0.
- R2: The slave ACKs an address byte whose upper seven bits equal `own_addr` with R/W (bit 0) = 0. For an address byte that matches neither `own_addr` nor a general call, it drives no ACK (the master sees SDA high).
- R3: In a write transfer, each data byte is ACKed and pushed into the receive queue. `rx_req` is high while the queue holds data. `rx_data` shows the oldest byte, and each `rx_pop` pulse removes one byte, so bytes leave in arrival order.
- R4: A data byte written while the receive queue already holds two bytes is NACKed and discarded, and `st_overflow` is set. The flag stays set until `clr_flags[1]` is pulsed.
- R5: While `sw_nack` is 1, written data bytes are NACKed and not stored, and `st_overflow` does not change.
- R6: An address byte that matches `own_addr` with R/W = 1 is NACKed when the transmit queue is empty.
- R7: In a read transfer, the address is ACKed when the transmit queue holds data. Each byte goes out MSB first in the order it was pushed, and the slave changes SDA only while SCL is low. `tx_full` is 1 when the queue holds two bytes.
- R8: If the master ACKs a byte and the transmit queue is empty, the slave sends the same byte again and sets `st_underflow`. The flag stays set until `clr_flags[0]` is pulsed.
- R9: When the master NACKs a byte the slave has sent, the slave releases SDA and returns to idle.
- R10: An address byte of 0x00 followed by a command byte of 0x06: both bytes are ACKed, the command byte is not stored, `st_gcall` is set, `gcid` becomes 1, and `if_reset` pulses high for exactly one clock. `clr_flags[2]` clears `st_gcall` and `gcid`.
- R11: An address byte of 0x00 followed by command 0x04 sets `st_gcall` and sets `gcid` to 2, with no `if_reset` pulse. An address byte of 0x01 is also ACKed as a general call, but no command after it changes the status.
- R12: `scl_oe` follows `hold_req` while the slave is in a transfer (from START until STOP, or until the slave leaves the transfer by NACKing or being NACKed), and is 0 while the slave is idle.
- R13: `irq` is 1 whenever `rx_req`, `st_underflow`, `st_overflow` or `st_gcall` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock hold) |
| sda_oe | output | 1 | Pull SDA low (ACK or a data 0) |
| own_addr | input | DW-1 | Own 7-bit slave address |
| sw_nack | input | 1 | Refuse bytes written by the master |
| hold_req | input | 1 | Request to hold SCL low |
| tx_data | input | DW | Byte to queue for transmit |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_full | output | 1 | Transmit queue holds two bytes |
| rx_data | output | DW | Oldest received byte |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_req | output | 1 | Receive queue holds data |
| clr_flags | input | 3 | Write-one-to-clear: bit0 underflow, bit1 overflow, bit2 general call and gcid |
| st_underflow | output | 1 | Sticky transmit underflow |
| st_overflow | output | 1 | Sticky receive overflow |
| st_gcall | output | 1 | Sticky general-call status |
| gcid | output | 2 | General-call identifier |
| if_reset | output | 1 | One-clock interface reset pulse |
| irq | output | 1 | Interrupt request |

## Verification
Write transfers are run three ways: into an empty queue, into a queue that fills on the third byte, and with the refusal input set. Together these separate the three acknowledge outcomes and show which of them store a byte and which raise overflow. Read transfers are run with an empty queue, with a full queue, and past the point where the queue runs dry. These separate the address NACK, plain in-order delivery, and the replay of the last byte with its underflow flag. General-call sequences with address 0x00 or 0x01 and commands 0x06 or 0x04 separate the two identifier values and the reset pulse. A hold request is given both inside a transfer and after STOP, to show that the hold applies only during a transfer.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } slv_state_e;

  localparam int CLR_UNDER = 0;
  localparam int CLR_OVER  = 1;
  localparam int CLR_GC    = 2;

  localparam int GC_CMD_RESET = 'h06;
  localparam int GC_CMD_ID    = 'h04;
endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [2:0] pipe_q;
    logic       val_q;
    logic       val_n;

    // Two synchronizer flops, then one history flop; change only on agreement.
    assign val_n = (pipe_q[2] == pipe_q[1]) ? pipe_q[1] : val_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= 3'b111;
        val_q  <= 1'b1;
      end else begin
        pipe_q <= {pipe_q[1:0], din[g]};
        val_q  <= val_n;
      end
    end

    assign dout[g] = val_q;
  end
endmodule

// File: rtl/i2cs_fifo.sv
module i2cs_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CNT_FULL);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem_q[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (do_push) wp_n = (wp_q == PTR_LAST) ? '0 : wp_q + AW'(1);
    if (do_pop)  rp_n = (rp_q == PTR_LAST) ? '0 : rp_q + AW'(1);
    if (do_push && !do_pop)      cnt_n = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
      if (do_push) mem_q[wp_q] <= wdata;
    end
  end
endmodule

// File: rtl/i2c_fifo_slave.sv
module i2c_fifo_slave
  import i2cs_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic [DW-2:0] own_addr,
  input  logic          sw_nack,
  input  logic          hold_req,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_push,
  output logic          tx_full,
  output logic [DW-1:0] rx_data,
  input  logic          rx_pop,
  output logic          rx_req,
  input  logic [2:0]    clr_flags,
  output logic          st_underflow,
  output logic          st_overflow,
  output logic          st_gcall,
  output logic [1:0]    gcid,
  output logic          if_reset,
  output logic          irq
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // Line conditioning and edge / condition detection.
  logic scl_f, sda_f, scl_d, sda_d;
  i2cs_glitch_filter #(.N(2)) u_filt (
    .clk  (clk),
    .rst_n(rst_ni),
    .din  ({sda_i, scl_i}),
    .dout ({sda_f, scl_f})
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  logic scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign bus_start = scl_f & scl_d & sda_d & ~sda_f;
  assign bus_stop  = scl_f & scl_d & ~sda_d & sda_f;

  // Queues.
  logic          tx_pop, tx_empty, rx_push, rx_full, rx_empty;
  logic [DW-1:0] tx_q;
  logic [DW-1:0] sh_q, sh_n;

  i2cs_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_ni), .push(tx_push), .wdata(tx_data),
    .pop(tx_pop), .rdata(tx_q), .full(tx_full), .empty(tx_empty)
  );

  i2cs_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_ni), .push(rx_push), .wdata(sh_q),
    .pop(rx_pop), .rdata(rx_data), .full(rx_full), .empty(rx_empty)
  );

  // Sequencer state.
  slv_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] txsh_q, txsh_n, txlast_q, txlast_n;
  logic          sda_oe_q, sda_oe_n;
  logic          first_q, first_n, rd_q, rd_n;
  logic          gcc_q, gcc_n, gc0_q, gc0_n;
  logic          und_q, und_n, ovf_q, ovf_n, gc_q, gc_n, ifr_q, ifr_n;
  logic [1:0]    gcid_q, gcid_n, gc_val;
  logic          set_und, set_ovf, set_gc;
  logic          addr_hit, gc_hit;

  assign addr_hit = (sh_q[DW-1:1] == own_addr);
  assign gc_hit   = (sh_q[DW-1:1] == '0);

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    txsh_n   = txsh_q;
    txlast_n = txlast_q;
    sda_oe_n = sda_oe_q;
    first_n  = first_q;
    rd_n     = rd_q;
    gcc_n    = gcc_q;
    gc0_n    = gc0_q;
    tx_pop   = 1'b0;
    rx_push  = 1'b0;
    set_und  = 1'b0;
    set_ovf  = 1'b0;
    set_gc   = 1'b0;
    gc_val   = 2'd0;
    ifr_n    = 1'b0;

    if (bus_start) begin
      st_n     = S_RX;
      cnt_n    = '0;
      first_n  = 1'b1;
      rd_n     = 1'b0;
      gcc_n    = 1'b0;
      sda_oe_n = 1'b0;
    end else if (bus_stop) begin
      st_n     = S_IDLE;
      sda_oe_n = 1'b0;
    end else begin
      case (st_q)
        S_RX: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_n  = {sh_q[DW-2:0], sda_f};
            cnt_n = cnt_q + CW'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (first_q) begin
              if (addr_hit && sh_q[0]) begin
                if (tx_empty) begin
                  st_n = S_IDLE;
                end else begin
                  tx_pop   = 1'b1;
                  txsh_n   = tx_q;
                  txlast_n = tx_q;
                  rd_n     = 1'b1;
                  sda_oe_n = 1'b1;
                  st_n     = S_ACK;
                end
              end else if (addr_hit || gc_hit) begin
                rd_n     = 1'b0;
                gcc_n    = gc_hit;
                gc0_n    = ~sh_q[0];
                sda_oe_n = 1'b1;
                st_n     = S_ACK;
              end else begin
                st_n = S_IDLE;
              end
            end else begin
              st_n = S_ACK;
              if (gcc_q) begin
                gcc_n    = 1'b0;
                sda_oe_n = 1'b1;
                if (gc0_q && sh_q == DW'(GC_CMD_RESET)) begin
                  set_gc = 1'b1;
                  gc_val = 2'd1;
                  ifr_n  = 1'b1;
                end else if (gc0_q && sh_q == DW'(GC_CMD_ID)) begin
                  set_gc = 1'b1;
                  gc_val = 2'd2;
                end
              end else if (sw_nack) begin
                sda_oe_n = 1'b0;
              end else if (rx_full) begin
                set_ovf = 1'b1;
              end else begin
                rx_push  = 1'b1;
                sda_oe_n = 1'b1;
              end
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            first_n = 1'b0;
            cnt_n   = '0;
            if (rd_q) begin
              st_n     = S_TX;
              sda_oe_n = ~txsh_q[DW-1];
            end else begin
              st_n     = S_RX;
              sda_oe_n = 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              st_n     = S_MACK;
              sda_oe_n = 1'b0;
            end else begin
              cnt_n    = cnt_q + CW'(1);
              txsh_n   = {txsh_q[DW-2:0], 1'b0};
              sda_oe_n = ~txsh_q[DW-2];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            if (sda_f) begin
              st_n = S_IDLE;
            end else if (!tx_empty) begin
              tx_pop   = 1'b1;
              txsh_n   = tx_q;
              txlast_n = tx_q;
            end else begin
              txsh_n  = txlast_q;
              set_und = 1'b1;
            end
          end else if (scl_fall) begin
            st_n     = S_TX;
            cnt_n    = '0;
            sda_oe_n = ~txsh_q[DW-1];
          end
        end
        default: ;
      endcase
    end

    und_n  = set_und | (und_q & ~clr_flags[CLR_UNDER]);
    ovf_n  = set_ovf | (ovf_q & ~clr_flags[CLR_OVER]);
    gc_n   = set_gc  | (gc_q  & ~clr_flags[CLR_GC]);
    gcid_n = set_gc ? gc_val : (clr_flags[CLR_GC] ? 2'd0 : gcid_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      txsh_q   <= '0;
      txlast_q <= '0;
      sda_oe_q <= 1'b0;
      first_q  <= 1'b0;
      rd_q     <= 1'b0;
      gcc_q    <= 1'b0;
      gc0_q    <= 1'b0;
      und_q    <= 1'b0;
      ovf_q    <= 1'b0;
      gc_q     <= 1'b0;
      gcid_q   <= 2'd0;
      ifr_q    <= 1'b0;
    end else begin
      st_q     <= st_n;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      txsh_q   <= txsh_n;
      txlast_q <= txlast_n;
      sda_oe_q <= sda_oe_n;
      first_q  <= first_n;
      rd_q     <= rd_n;
      gcc_q    <= gcc_n;
      gc0_q    <= gc0_n;
      und_q    <= und_n;
      ovf_q    <= ovf_n;
      gc_q     <= gc_n;
      gcid_q   <= gcid_n;
      ifr_q    <= ifr_n;
    end
  end

  logic is_idle;
  assign is_idle      = (st_q == S_IDLE);
  assign sda_oe       = sda_oe_q;
  assign scl_oe       = hold_req & ~is_idle;
  assign rx_req       = ~rx_empty;
  assign st_underflow = und_q;
  assign st_overflow  = ovf_q;
  assign st_gcall     = gc_q;
  assign gcid         = gcid_q;
  assign if_reset     = ifr_q;
  assign irq          = rx_req | und_q | ovf_q | gc_q;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       hold_req,
  input logic       is_idle,
  input logic       st_overflow,
  input logic       st_gcall,
  input logic       clr_ovf,
  input logic [1:0] gcid,
  input logic       if_reset
);
  assert_sda_low_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> !sda_oe);

  assert_no_overflow_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overflow && !clr_ovf) |=> st_overflow);

  assert_gcid_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gcid != 2'd0) |-> (st_gcall && gcid != 2'd3));

  assert_reset_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    if_reset |=> !if_reset);

  assert_hold_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> hold_req);
endmodule

bind i2c_fifo_slave i2cs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_f      (scl_f),
  .sda_oe     (sda_oe),
  .scl_oe     (scl_oe),
  .hold_req   (hold_req),
  .is_idle    (is_idle),
  .st_overflow(st_overflow),
  .st_gcall   (st_gcall),
  .clr_ovf    (clr_flags[1]),
  .gcid       (gcid),
  .if_reset   (if_reset)
);

// File: tb/i2c_fifo_slave_tb.sv
module i2c_fifo_slave_tb;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       m_scl_oe, m_sda_oe;
  logic       scl_oe, sda_oe, scl_line, sda_line;
  logic       sw_nack, hold_req, tx_push, rx_pop;
  logic [7:0] tx_data, rx_data;
  logic       tx_full, rx_req, st_underflow, st_overflow, st_gcall, if_reset, irq;
  logic [2:0] clr_flags;
  logic [1:0] gcid;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  assign scl_line = ~(m_scl_oe | scl_oe);
  assign sda_line = ~(m_sda_oe | sda_oe);

  i2c_fifo_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .sw_nack(sw_nack),
    .hold_req(hold_req), .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full),
    .rx_data(rx_data), .rx_pop(rx_pop), .rx_req(rx_req), .clr_flags(clr_flags),
    .st_underflow(st_underflow), .st_overflow(st_overflow), .st_gcall(st_gcall),
    .gcid(gcid), .if_reset(if_reset), .irq(irq)
  );

  always @(posedge clk) if (if_reset === 1'b1) pulses <= pulses + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda_oe = 1'b1; tick(2*Q);
    m_scl_oe = 1'b1; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda_oe = 1'b1; tick(Q);
    m_scl_oe = 1'b0; wait (scl_line === 1'b1); tick(2*Q);
    m_sda_oe = 1'b0; tick(2*Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda_oe = ~b; tick(Q);
    m_scl_oe = 1'b0; wait (scl_line === 1'b1); tick(2*Q);
    m_scl_oe = 1'b1; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda_oe = 1'b0; tick(Q);
    m_scl_oe = 1'b0; wait (scl_line === 1'b1); tick(Q);
    b = sda_line; tick(Q);
    m_scl_oe = 1'b1; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(nack);
  endtask

  task automatic get_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(nack);
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_data = d; tx_push = 1'b1; tick(1); tx_push = 1'b0; tick(1);
  endtask

  task automatic pop_rx();
    rx_pop = 1'b1; tick(1); rx_pop = 1'b0; tick(1);
  endtask

  task automatic clear(input logic [2:0] m);
    clr_flags = m; tick(1); clr_flags = 3'b000; tick(1);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 rx_req", rx_req, 0);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 flags", {st_underflow, st_overflow, st_gcall, gcid, if_reset}, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_wrong_addr();
    logic n;
    bus_start(); put_byte({7'h33, 1'b0}, n); bus_stop();
    chk("R2 foreign address not acked", n, 1);
  endtask

  task automatic t_write();
    logic n;
    bus_start(); put_byte({OWN, 1'b0}, n);
    chk("R2 own address write acked", n, 0);
    put_byte(8'hA5, n); chk("R3 byte0 ack", n, 0);
    put_byte(8'h3C, n); chk("R3 byte1 ack", n, 0);
    bus_stop();
    chk("R3 rx_req set", rx_req, 1);
    chk("R13 irq from rx_req", irq, 1);
    chk("R3 first out", rx_data, 8'hA5); pop_rx();
    chk("R3 second out", rx_data, 8'h3C); pop_rx();
    chk("R3 rx_req clear", rx_req, 0);
    chk("R13 irq idle", irq, 0);
  endtask

  task automatic t_overflow();
    logic n;
    bus_start(); put_byte({OWN, 1'b0}, n);
    put_byte(8'h11, n); chk("R4 fill 1 ack", n, 0);
    put_byte(8'h22, n); chk("R4 fill 2 ack", n, 0);
    put_byte(8'h33, n); chk("R4 full byte nack", n, 1);
    bus_stop();
    chk("R4 overflow set", st_overflow, 1);
    chk("R4 kept oldest", rx_data, 8'h11); pop_rx();
    chk("R4 third dropped", rx_data, 8'h22); pop_rx();
    chk("R4 empty after two", rx_req, 0);
    chk("R13 irq from overflow", irq, 1);
    clear(3'b010);
    chk("R4 overflow cleared", st_overflow, 0);
    chk("R13 irq clear", irq, 0);
  endtask

  task automatic t_swnack();
    logic n;
    sw_nack = 1'b1;
    bus_start(); put_byte({OWN, 1'b0}, n);
    put_byte(8'h77, n); chk("R5 refused byte", n, 1);
    bus_stop();
    sw_nack = 1'b0;
    chk("R5 not stored", rx_req, 0);
    chk("R5 no overflow", st_overflow, 0);
  endtask

  task automatic t_read_empty();
    logic n;
    bus_start(); put_byte({OWN, 1'b1}, n); bus_stop();
    chk("R6 read with empty queue nacked", n, 1);
    chk("R6 line released", sda_oe, 0);
  endtask

  task automatic t_read();
    logic n;
    logic [7:0] b;
    push_tx(8'hC3); push_tx(8'h5E);
    chk("R7 tx_full", tx_full, 1);
    bus_start(); put_byte({OWN, 1'b1}, n);
    chk("R7 read address acked", n, 0);
    get_byte(b, 1'b0); chk("R7 first byte", b, 8'hC3);
    chk("R8 no underflow yet", st_underflow, 0);
    get_byte(b, 1'b0); chk("R7 second byte", b, 8'h5E);
    chk("R8 underflow on dry queue", st_underflow, 1);
    get_byte(b, 1'b1); chk("R8 replayed byte", b, 8'h5E);
    tick(Q);
    chk("R9 released after master nack", sda_oe, 0);
    chk("R9 line high", sda_line, 1);
    bus_stop();
    clear(3'b001);
    chk("R8 underflow cleared", st_underflow, 0);
  endtask

  task automatic t_gc_reset();
    logic n;
    pulses = 0;
    bus_start(); put_byte(8'h00, n); chk("R10 gc address ack", n, 0);
    put_byte(8'h06, n); chk("R10 command ack", n, 0);
    bus_stop();
    chk("R10 gcall", st_gcall, 1);
    chk("R10 gcid", gcid, 1);
    chk("R10 one reset pulse", pulses, 1);
    chk("R10 command not stored", rx_req, 0);
    clear(3'b100);
    chk("R10 gc cleared", {st_gcall, gcid}, 0);
  endtask

  task automatic t_gc_id();
    logic n;
    pulses = 0;
    bus_start(); put_byte(8'h00, n); put_byte(8'h04, n);
    chk("R11 cmd4 ack", n, 0);
    bus_stop();
    chk("R11 gcid two", gcid, 2);
    chk("R11 gcall", st_gcall, 1);
    chk("R11 no pulse", pulses, 0);
    clear(3'b100);
    bus_start(); put_byte(8'h01, n); chk("R11 address 0x01 acked", n, 0);
    put_byte(8'h06, n); bus_stop();
    chk("R11 no status after 0x01", {st_gcall, gcid}, 0);
    chk("R11 no pulse after 0x01", pulses, 0);
  endtask

  task automatic t_hold();
    logic n;
    bus_start(); put_byte({OWN, 1'b0}, n);
    hold_req = 1'b1; tick(6);
    chk("R12 hold inside transfer", scl_oe, 1);
    hold_req = 1'b0; tick(2);
    put_byte(8'h42, n); bus_stop();
    chk("R3 byte after hold", rx_data, 8'h42); pop_rx();
    hold_req = 1'b1; tick(6);
    chk("R12 no hold when idle", scl_oe, 0);
    hold_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; m_scl_oe = 1'b0; m_sda_oe = 1'b0;
    sw_nack = 1'b0; hold_req = 1'b0; tx_push = 1'b0; rx_pop = 1'b0;
    tx_data = 8'h00; clr_flags = 3'b000;
    tick(5); rst_n = 1'b1; tick(20);
    t_reset();
    t_wrong_addr();
    t_write();
    t_overflow();
    t_swnack();
    t_read_empty();
    t_read();
    t_gc_reset();
    t_gc_id();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL all watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule